// File: doc/BRIEF.md
# Sync-Gated Receive Byte Queue

This block watches a demodulated bit stream, one bit per strobe, for a 16-bit synchronization word. Its upper byte is fixed at 0x2D and its lower byte is set by the host. Until that word has been seen with filling enabled, received bits are only correlated and none are stored. After a match, each later bit is shifted into a byte, most significant bit first, and every complete byte is pushed into a 16-entry queue.

The host talks to the block through 16-bit command words, each marked by a one-cycle valid. Commands set the low byte of the sync word, turn filling on or off, enable reads, and pop one byte. A sync search is armed only when the fill-enable control goes from cleared to set. While it stays set, a block that is already filling keeps filling, and writing "set" again does nothing. Clearing fill-enable empties the queue, drops any partial byte, clears the overflow flag and returns the block to searching.

Top module: `sync_rx_top`

## Requirements
- R1: While fill-enable is set and the block is searching, each bit strobe compares the last 16 bits (the current bit as LSB, earlier bits above it) with {0x2D, low byte}. On a match `sync_o` rises after that edge. The matching bit is not stored, and the first data bit is the next strobed bit. With fill-enable cleared, no match is taken.
- R2: The command with upper byte 0xCA sets fill-enable from bit 1. Writing 0 returns the block to search, empties the queue, discards a partially packed byte and clears `ovf_o`. All of this is visible at the ports by the second clock edge after the command.
- R3: While filling, the block stays in the fill state as long as fill-enable stays set. A repeated 0xCA command with bit 1 set does not restart the search, and a later copy of the sync word is stored as data.
- R4: The command with upper byte 0xCE loads the sync word low byte from bits 7:0. After reset the low byte is 0xD4 and the full word is 0x2DD4.
- R5: The command with upper byte 0x80 sets read-enable from bit 6 (reset value 0). A read while read-enable is 0 returns 0x00 and does not remove a byte.
- R6: Data bits are packed MSB first. The byte is pushed on the edge of its 8th strobe, and `avail_o` is high from that edge on while the queue is not empty.
- R7: Command 0xB000 reads one byte. `rd_vld_o` pulses for exactly one cycle after the edge that takes the command, with `rd_data_o` holding the oldest stored byte. Bytes come out in arrival order, and `rd_vld_o` never pulses without a read command.
- R8: A read from an empty queue returns 0x00 and removes nothing.
- R9: The queue holds 16 bytes. A byte completed while the queue is full is dropped, and it sets `ovf_o`, which stays high until fill-enable is cleared or reset.
- R10: After reset, `sync_o`, `avail_o`, `ovf_o` and `rd_vld_o` are low, fill-enable and read-enable are cleared, and `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_vld_i | input | 1 | Strobe: `bit_i` is valid this cycle |
| bit_i | input | 1 | Received data bit |
| cmd_vld_i | input | 1 | Command word valid for one cycle |
| cmd_i | input | 16 | Host command word |
| rd_vld_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Read result byte |
| avail_o | output | 1 | At least one byte is stored |
| ovf_o | output | 1 | Sticky overflow flag |
| sync_o | output | 1 | Sync found, block is filling |

## Verification
A correlator that shifts or compares wrongly shows up as `sync_o` rising on the wrong bit or never rising, one cycle after the strobe concerned. A packing counter that is wrong, or that is not cleared, shows up later as shifted bytes at the next read. Pointer or count errors appear as out-of-order, missing or duplicated bytes, as nonzero data from an empty read, or as `ovf_o` rising one byte too early or too late. A flush that is missed leaves stale bytes that surface on the first read after the block has synchronized again.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SYNC_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0] SYNC_HI = 8'h2D;
  localparam logic [7:0] SYNC_LO_RST = 8'hD4;

  localparam logic [7:0]  OP_SYNC = 8'hCE;
  localparam logic [7:0]  OP_FILL = 8'hCA;
  localparam logic [7:0]  OP_CFG  = 8'h80;
  localparam logic [15:0] OP_READ = 16'hB000;
  localparam int unsigned FILL_BIT = 1;
  localparam int unsigned RDEN_BIT = 6;

  typedef enum logic {ST_SEARCH = 1'b0, ST_FILL = 1'b1} fill_st_e;
endpackage

// File: rtl/srx_cmd.sv
module srx_cmd
  import srx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_vld_i,
  input  logic [15:0] cmd_i,
  output logic [7:0]  sync_lo_o,
  output logic        fill_en_o,
  output logic        rd_en_o,
  output logic        rd_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_lo_o <= SYNC_LO_RST;
      fill_en_o <= 1'b0;
      rd_en_o   <= 1'b0;
    end else if (cmd_vld_i) begin
      case (cmd_i[15:8])
        OP_SYNC: sync_lo_o <= cmd_i[7:0];
        OP_FILL: fill_en_o <= cmd_i[FILL_BIT];
        OP_CFG:  rd_en_o   <= cmd_i[RDEN_BIT];
        default: ;
      endcase
    end
  end

  assign rd_req_o = cmd_vld_i && (cmd_i == OP_READ);
endmodule

// File: rtl/srx_correlator.sv
module srx_correlator #(
  parameter int unsigned SYNC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  output logic              match_o
);
  logic [SYNC_W-2:0] hist_q;
  logic [SYNC_W-1:0] win;

  assign win = {hist_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= '0;
    else if (bit_vld_i) hist_q <= win[SYNC_W-2:0];
  end

  assign match_o = bit_vld_i && (win == sync_word_i);
endmodule

// File: rtl/srx_packer.sv
module srx_packer
  import srx_pkg::*;
#(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_en_i,
  input  logic          bit_vld_i,
  input  logic          bit_i,
  input  logic          match_i,
  output logic          filling_o,
  output logic          push_o,
  output logic [BW-1:0] push_data_o
);
  localparam int unsigned CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  fill_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_SEARCH;
      cnt_q <= '0;
      sr_q  <= '0;
    end else if (!fill_en_i) begin
      st_q  <= ST_SEARCH;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      case (st_q)
        ST_SEARCH: if (match_i) st_q <= ST_FILL;
        ST_FILL: if (bit_vld_i) begin
          sr_q  <= {sr_q[BW-3:0], bit_i};
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
        default: st_q <= ST_SEARCH;
      endcase
    end
  end

  assign filling_o   = (st_q == ST_FILL);
  assign push_o      = filling_o && fill_en_i && bit_vld_i && (cnt_q == LAST);
  assign push_data_o = {sr_q, bit_i};
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_req_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvld_o,
  output logic          avail_o,
  output logic          ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, wr, pop;

  function automatic logic [AW-1:0] ptr_nxt(input logic [AW-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CNT_FULL);
  assign empty = (cnt_q == '0);
  assign wr    = push_i && !full && !flush_i;
  assign pop   = rd_req_i && rd_en_i && !empty && !flush_i;

  always_ff @(posedge clk_i) begin
    if (wr) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_o  <= 1'b0;
    end else begin
      if (wr)  wptr_q <= ptr_nxt(wptr_q);
      if (pop) rptr_q <= ptr_nxt(rptr_q);
      if (push_i && full) ovf_o <= 1'b1;
      case ({wr, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      rvld_o  <= 1'b0;
    end else begin
      rvld_o  <= rd_req_i;
      rdata_o <= pop ? mem_q[rptr_q] : '0;
    end
  end

  assign avail_o = !empty;
endmodule

// File: rtl/sync_rx_top.sv
module sync_rx_top
  import srx_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_vld_i,
  input  logic        bit_i,
  input  logic        cmd_vld_i,
  input  logic [15:0] cmd_i,
  output logic        rd_vld_o,
  output logic [7:0]  rd_data_o,
  output logic        avail_o,
  output logic        ovf_o,
  output logic        sync_o
);
  logic [7:0]        sync_lo;
  logic              fill_en, rd_en, rd_req, match, push;
  logic [BYTE_W-1:0] push_data;

  srx_cmd u_cmd (
    .clk_i, .rst_ni, .cmd_vld_i, .cmd_i,
    .sync_lo_o(sync_lo), .fill_en_o(fill_en), .rd_en_o(rd_en), .rd_req_o(rd_req)
  );

  srx_correlator #(.SYNC_W(SYNC_W)) u_corr (
    .clk_i, .rst_ni, .bit_vld_i, .bit_i,
    .sync_word_i({SYNC_HI, sync_lo}), .match_o(match)
  );

  srx_packer #(.BW(BYTE_W)) u_pack (
    .clk_i, .rst_ni, .fill_en_i(fill_en), .bit_vld_i, .bit_i,
    .match_i(match), .filling_o(sync_o), .push_o(push), .push_data_o(push_data)
  );

  srx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk_i, .rst_ni, .flush_i(!fill_en), .push_i(push), .wdata_i(push_data),
    .rd_req_i(rd_req), .rd_en_i(rd_en), .rdata_o(rd_data_o), .rvld_o(rd_vld_o),
    .avail_o, .ovf_o
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_vld_i,
  input logic [15:0] cmd_i,
  input logic        fill_en_i,
  input logic        rd_en_i,
  input logic        rd_vld_o,
  input logic [7:0]  rd_data_o,
  input logic        avail_o,
  input logic        ovf_o,
  input logic        sync_o
);
  logic is_rd;
  assign is_rd = cmd_vld_i && (cmd_i == 16'hB000);

  AST_PUSH_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(avail_o) |-> $past(sync_o)); // R1
  AST_FLUSH_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_en_i |=> (!sync_o && !avail_o && !ovf_o)); // R2
  AST_FILL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && fill_en_i) |=> sync_o); // R3
  AST_RD_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !rd_en_i) |=> (rd_vld_o && rd_data_o == 8'h00)); // R5
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rd |=> !rd_vld_o); // R7
  AST_RD_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && !avail_o) |=> (rd_vld_o && rd_data_o == 8'h00)); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && fill_en_i) |=> ovf_o); // R9
endmodule

bind sync_rx_top srx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i),
  .fill_en_i(fill_en), .rd_en_i(rd_en), .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o),
  .avail_o(avail_o), .ovf_o(ovf_o), .sync_o(sync_o)
);

// File: tb/sync_rx_top_tb.sv
`timescale 1ns/1ps
module sync_rx_top_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_vld_i = 1'b0, bit_i = 1'b0, cmd_vld_i = 1'b0;
  logic [15:0] cmd_i = '0;
  logic        rd_vld_o, avail_o, ovf_o, sync_o;
  logic [7:0]  rd_data_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  sync_rx_top u_dut (
    .clk_i(clk), .rst_ni, .bit_vld_i, .bit_i, .cmd_vld_i, .cmd_i,
    .rd_vld_o, .rd_data_o, .avail_o, .ovf_o, .sync_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares every read result with the scoreboard
  always @(negedge clk) begin
    if (rst_ni && rd_vld_o) begin
      if (exp_q.size() == 0) chk("R7 unexpected rd_vld", 8'h01, 8'h00);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rd_data_o, e);
      end
    end
  end

  task automatic send_cmd(input logic [15:0] w);
    @(negedge clk); cmd_vld_i = 1'b1; cmd_i = w;
    @(negedge clk); cmd_vld_i = 1'b0; cmd_i = '0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_vld_i = 1'b1; bit_i = b;
    @(negedge clk); bit_vld_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic rd_expect(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
    send_cmd(16'hB000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 sync_o", {7'd0, sync_o}, 8'h00);
    chk("R10 avail_o", {7'd0, avail_o}, 8'h00);
    chk("R10 ovf_o", {7'd0, ovf_o}, 8'h00);
    chk("R10 rd_vld_o", {7'd0, rd_vld_o}, 8'h00);
    chk("R10 rd_data_o", rd_data_o, 8'h00);

    send_cmd(16'h8040);
    rd_expect(8'h00, "R8 empty read");

    // R1: no match taken while fill disabled
    send_byte(8'h2D); send_byte(8'hD4);
    chk("R1 no sync without fill-enable", {7'd0, sync_o}, 8'h00);

    send_cmd(16'hCA02);
    send_byte(8'h2D);
    for (int i = 7; i >= 1; i--) send_bit(8'hD4 >> i);
    chk("R1 no sync before last bit", {7'd0, sync_o}, 8'h00);
    send_bit(1'b0);
    chk("R1 sync on match", {7'd0, sync_o}, 8'h01);
    chk("R1 matching bit not stored", {7'd0, avail_o}, 8'h00);

    // R6 packing and push timing
    for (int i = 7; i >= 1; i--) send_bit(8'hA5 >> i);
    chk("R6 no byte after 7 bits", {7'd0, avail_o}, 8'h00);
    send_bit(1'b1);
    chk("R6 avail after 8th bit", {7'd0, avail_o}, 8'h01);
    send_byte(8'h3C);

    // R3 repeated set does not re-arm; sync word stored as data
    send_cmd(16'hCA02);
    chk("R3 still filling", {7'd0, sync_o}, 8'h01);
    send_byte(8'h2D); send_byte(8'hD4);
    rd_expect(8'hA5, "R6 first byte");
    rd_expect(8'h3C, "R7 order");
    rd_expect(8'h2D, "R3 sync stored as data");
    rd_expect(8'hD4, "R3 sync stored as data");
    rd_expect(8'h00, "R8 empty after drain");
    chk("R8 avail low", {7'd0, avail_o}, 8'h00);

    // R5 read disabled
    send_byte(8'h77);
    send_cmd(16'h8000);
    rd_expect(8'h00, "R5 read disabled");
    chk("R5 byte kept", {7'd0, avail_o}, 8'h01);
    send_cmd(16'h8040);
    rd_expect(8'h77, "R5 byte after re-enable");

    // R9 overflow
    for (int i = 0; i < 16; i++) send_byte(8'(i * 7 + 3));
    chk("R9 no overflow at 16", {7'd0, ovf_o}, 8'h00);
    send_byte(8'hEE);
    chk("R9 overflow set", {7'd0, ovf_o}, 8'h01);
    for (int i = 0; i < 16; i++) rd_expect(8'(i * 7 + 3), "R9 kept bytes");
    rd_expect(8'h00, "R9 dropped byte absent");
    chk("R9 overflow sticky", {7'd0, ovf_o}, 8'h01);

    // R2 clear with a partial byte pending
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_byte(8'h11);
    send_cmd(16'hCA00);
    @(negedge clk);
    chk("R2 sync cleared", {7'd0, sync_o}, 8'h00);
    chk("R2 queue emptied", {7'd0, avail_o}, 8'h00);
    chk("R2 overflow cleared", {7'd0, ovf_o}, 8'h00);

    // R4 new low byte
    send_cmd(16'hCE99);
    send_cmd(16'hCA02);
    send_byte(8'h2D); send_byte(8'hD4);
    chk("R4 old word ignored", {7'd0, sync_o}, 8'h00);
    send_byte(8'h2D); send_byte(8'h99);
    chk("R4 new word matches", {7'd0, sync_o}, 8'h01);
    send_byte(8'h5A);
    rd_expect(8'h5A, "R2 packing restarted");
    rd_expect(8'h00, "R2 no stale bytes");

    repeat (4) @(negedge clk);
    chk("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule